// File: doc/BRIEF.md
# Memory Access Width Formatter

This block sits between a 32-bit register file and a byte-addressable memory data path. For loads it takes a 32-bit memory read word whose low lanes hold an 8-bit or 16-bit value and widens that value to a full 32-bit register value. A signed access replicates the value's top bit into the upper bits (sign extension). An unsigned access fills the upper bits with zeros. A word access passes all 32 bits through unchanged.

For stores it cuts the register value down to the access width, places it in the low lanes of the store data output and drives the byte enables to match. A signed narrow store also checks whether the register value fits the signed range of the target width. When it does not fit, a mask input chooses the outcome: either a sticky overflow flag is set, or a one-cycle fault request is raised. All formatting is combinational. Only the sticky flag and the fault pulse are registered.

Top module: `ldst_fmt_top`

## Requirements
- R1: With `acc_load`=1, `acc_signed`=1 and `acc_size`=2'b00 (byte), `ld_result` equals `mem_rdata[7:0]` with bit 7 copied into bits 31..8. Example: 0x7A gives 0x0000007A and 0xFA gives 0xFFFFFFFA.
- R2: With `acc_load`=1, `acc_signed`=1 and `acc_size`=2'b01 (short), `ld_result` equals `mem_rdata[15:0]` with bit 15 copied into bits 31..16. Example: 0x05A5 gives 0x000005A5 and 0x85A5 gives 0xFFFF85A5.
- R3: An unsigned load (`acc_signed`=0) of byte or short size puts zeros above the loaded value.
- R4: A word access (`acc_size`=2'b10) returns `mem_rdata` unchanged on `ld_result`. For a store it drives `st_wdata` equal to `reg_wdata` with `st_be`=4'b1111, and it never signals overflow.
- R5: A byte store drives `st_wdata`={24'b0, reg_wdata[7:0]} with `st_be`=4'b0001. A short store drives `st_wdata`={16'b0, reg_wdata[15:0]} with `st_be`=4'b0011.
- R6: A signed byte store overflows exactly when `reg_wdata[31:7]` are not all equal. A signed short store overflows exactly when `reg_wdata[31:15]` are not all equal. Unsigned stores never overflow.
- R7: An overflowing store with `acc_valid`=1 and `ovf_mask`=1 sets `ovf_sticky` at the next clock edge and raises no fault.
- R8: An overflowing store with `acc_valid`=1 and `ovf_mask`=0 drives `ovf_fault`=1 for exactly the one cycle after that edge and leaves `ovf_sticky` unchanged.
- R9: `ovf_sticky` keeps its value until `ovf_clear` is sampled high or reset is applied. When a set and a clear arrive in the same cycle, the clear wins. Both registered outputs are 0 after reset.
- R10: Nothing updates the registered outputs unless `acc_valid`=1 and `acc_load`=0. An overflowing operand presented with either condition failing leaves `ovf_sticky` and `ovf_fault` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe for this cycle |
| acc_load | input | 1 | 1 = load, 0 = store |
| acc_signed | input | 1 | 1 = signed integer, 0 = unsigned ordinal |
| acc_size | input | 2 | 00 byte, 01 short, 10 word |
| ovf_mask | input | 1 | 1 = overflow sets sticky flag, 0 = fault request |
| ovf_clear | input | 1 | Clears the sticky flag |
| reg_wdata | input | 32 | Register value to store |
| mem_rdata | input | 32 | Memory read data, value in low lanes |
| ld_result | output | 32 | Extended load value |
| st_wdata | output | 32 | Truncated store data, low lanes |
| st_be | output | 4 | Store byte enables |
| ovf_sticky | output | 1 | Sticky overflow flag |
| ovf_fault | output | 1 | One-cycle overflow fault request |

## Verification
The assertions assume that `acc_size` never carries the reserved code 2'b11 while an access is valid. They also assume that the control inputs are stable around each rising edge. The bench only ever applies sizes 00, 01 and 10, and it changes inputs on the falling edge. The registered checks compare each flag against the operands of the previous cycle, so they rely on reset being released before the first access. The bench holds reset over several edges before it issues its first vector.

// File: rtl/ldst_fmt_pkg.sv
// Package: shared access-size encoding and data widths for the formatter.
// Assumes a 32-bit register and data path built from 8-bit lanes.
package ldst_fmt_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int HALF_W = 2 * LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_SHORT = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_RSVD  = 2'b11
    } acc_size_e;
endpackage

// File: rtl/ldst_load_ext.sv
// Module: widens a narrow memory value to a full register value.
// Assumes the narrow value sits in the low lanes of mem_rdata.
// A reserved size is treated as a word access.
module ldst_load_ext
    import ldst_fmt_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int BW = LANE_W,
    parameter int HW = HALF_W
) (
    input  logic [W-1:0] rdata,
    input  logic         sgn,
    input  logic [1:0]   size,
    output logic [W-1:0] result
);
    logic fill_b;
    logic fill_h;

    // Pick the fill bit for each narrow size: the value's top bit when signed, zero otherwise.
    always_comb begin
        fill_b = sgn & rdata[BW-1];
        fill_h = sgn & rdata[HW-1];
    end

    // Place the low bits and fill the upper bits according to the size.
    always_comb begin
        case (size)
            SZ_BYTE:  result = {{(W-BW){fill_b}}, rdata[BW-1:0]};
            SZ_SHORT: result = {{(W-HW){fill_h}}, rdata[HW-1:0]};
            default:  result = rdata;
        endcase
    end
endmodule

// File: rtl/ldst_store_trunc.sv
// Module: truncates a register value for a store and detects signed misfit.
// Assumes the value goes to the low lanes and the byte enables mark those lanes.
// A reserved size is treated as a word access.
module ldst_store_trunc
    import ldst_fmt_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int BW = LANE_W,
    parameter int HW = HALF_W,
    parameter int NL = LANES
) (
    input  logic [W-1:0]  wdata_in,
    input  logic          sgn,
    input  logic [1:0]    size,
    output logic [W-1:0]  wdata_out,
    output logic [NL-1:0] be,
    output logic          misfit
);
    localparam int BL = BW / LANE_W;
    localparam int HL = HW / LANE_W;

    logic fits_b;
    logic fits_h;

    // Range test: the value fits when every bit from the target width's top bit up to bit W-1 matches.
    always_comb begin
        fits_b = (wdata_in[W-1:BW-1] == {(W-BW+1){wdata_in[W-1]}});
        fits_h = (wdata_in[W-1:HW-1] == {(W-HW+1){wdata_in[W-1]}});
    end

    // Truncate the data, set the lane enables, and flag a signed value that does not fit.
    always_comb begin
        case (size)
            SZ_BYTE: begin
                wdata_out = {{(W-BW){1'b0}}, wdata_in[BW-1:0]};
                be        = NL'((1 << BL) - 1);
                misfit    = sgn & ~fits_b;
            end
            SZ_SHORT: begin
                wdata_out = {{(W-HW){1'b0}}, wdata_in[HW-1:0]};
                be        = NL'((1 << HL) - 1);
                misfit    = sgn & ~fits_h;
            end
            default: begin
                wdata_out = wdata_in;
                be        = {NL{1'b1}};
                misfit    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ldst_ovf_ctl.sv
// Module: routes a store overflow to the sticky flag or to a fault pulse.
// Assumes a synchronous active-low reset, and that a clear overrides a set in the same cycle.
module ldst_ovf_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_evt,
    input  logic mask,
    input  logic clr,
    output logic sticky,
    output logic fault
);
    // Sticky flag: set by a masked overflow, held until cleared or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sticky <= 1'b0;
        else if (ovf_evt && mask) sticky <= 1'b1;
    end

    // Fault request: a one-cycle pulse for each unmasked overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) fault <= 1'b0;
        else fault <= ovf_evt & ~mask;
    end
endmodule

// File: rtl/ldst_fmt_top.sv
// Module: load/store width formatter top.
// Joins the load extender, the store truncator and the overflow control.
// Assumes that acc_size is never 2'b11 while acc_valid is high.
module ldst_fmt_top
    import ldst_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_load,
    input  logic              acc_signed,
    input  logic [1:0]        acc_size,
    input  logic              ovf_mask,
    input  logic              ovf_clear,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] ld_result,
    output logic [DATA_W-1:0] st_wdata,
    output logic [LANES-1:0]  st_be,
    output logic              ovf_sticky,
    output logic              ovf_fault
);
    logic misfit;
    logic ovf_evt;

    // Qualify the store overflow with the valid strobe and the store direction.
    always_comb ovf_evt = acc_valid & ~acc_load & misfit;

    ldst_load_ext u_ld (
        .rdata (mem_rdata),
        .sgn   (acc_signed),
        .size  (acc_size),
        .result(ld_result)
    );

    ldst_store_trunc u_st (
        .wdata_in (reg_wdata),
        .sgn      (acc_signed),
        .size     (acc_size),
        .wdata_out(st_wdata),
        .be       (st_be),
        .misfit   (misfit)
    );

    ldst_ovf_ctl u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf_evt(ovf_evt),
        .mask  (ovf_mask),
        .clr   (ovf_clear),
        .sticky(ovf_sticky),
        .fault (ovf_fault)
    );
endmodule

// File: rtl/ldst_fmt_chk.sv
// Checker: temporal and port-level properties of the formatter, bound to the top.
// Assumes legal sizes while valid and a synchronous active-low reset.
module ldst_fmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_load,
    input logic        acc_signed,
    input logic [1:0]  acc_size,
    input logic        ovf_mask,
    input logic        ovf_clear,
    input logic [31:0] reg_wdata,
    input logic [31:0] mem_rdata,
    input logic [31:0] ld_result,
    input logic [31:0] st_wdata,
    input logic [3:0]  st_be,
    input logic        ovf_sticky,
    input logic        ovf_fault
);
    logic bad_b;
    logic bad_h;
    logic store_ovf;

    // Reference misfit test, written from the range definition rather than from bit equality.
    always_comb begin
        bad_b = ($signed(reg_wdata) > 127) || ($signed(reg_wdata) < -128);
        bad_h = ($signed(reg_wdata) > 32767) || ($signed(reg_wdata) < -32768);
        store_ovf = acc_valid && !acc_load && acc_signed &&
                    ((acc_size == 2'b00 && bad_b) || (acc_size == 2'b01 && bad_h));
    end

    AST_BYTE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_signed && acc_size == 2'b00) |-> $signed(ld_result) == $signed(mem_rdata[7:0])); // R1
    AST_SHORT_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_signed && acc_size == 2'b01) |-> $signed(ld_result) == $signed(mem_rdata[15:0])); // R2
    AST_UNSIGNED_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_signed && acc_size != 2'b10) |-> ld_result[31:16] == 16'h0); // R3
    AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b10) |-> (ld_result == mem_rdata && st_wdata == reg_wdata)); // R4
    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size != 2'b11) |-> ($countones(st_be) == (acc_size == 2'b00 ? 1 : acc_size == 2'b01 ? 2 : 4) && st_be[0])); // R5
    AST_MASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (store_ovf && ovf_mask && !ovf_clear) |=> (ovf_sticky && !ovf_fault)); // R7
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (store_ovf && !ovf_mask) |=> ovf_fault); // R8
    AST_NO_SPURIOUS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !store_ovf |=> !ovf_fault); // R6
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_clear && !(store_ovf && ovf_mask)) |=> $stable(ovf_sticky)); // R9
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clear |=> !ovf_sticky); // R9
    AST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || acc_load) |=> !ovf_fault); // R10
endmodule

bind ldst_fmt_top ldst_fmt_chk u_chk (.*);

// File: tb/ldst_fmt_top_tb_top.sv
// Bench: a vector table for the combinational formatting, then directed tests of the registered flags.
module ldst_fmt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_load, acc_signed, ovf_mask, ovf_clear;
    logic [1:0]  acc_size;
    logic [31:0] reg_wdata, mem_rdata;
    logic [31:0] ld_result, st_wdata;
    logic [3:0]  st_be;
    logic        ovf_sticky, ovf_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ldst_fmt_top dut_i (.*);

    // Vector fields: load, signed, size, data, expected word output, expected byte enables
    typedef struct packed {
        logic        ld;
        logic        sg;
        logic [1:0]  sz;
        logic [31:0] din;
        logic [31:0] exp;
        logic [3:0]  be;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 2'b00, 32'h1234_567A, 32'h0000_007A, 4'h0},  // R1
        '{1'b1, 1'b1, 2'b00, 32'hABCD_00FA, 32'hFFFF_FFFA, 4'h0},  // R1
        '{1'b1, 1'b1, 2'b01, 32'hFFFF_05A5, 32'h0000_05A5, 4'h0},  // R2
        '{1'b1, 1'b1, 2'b01, 32'h0000_85A5, 32'hFFFF_85A5, 4'h0},  // R2
        '{1'b1, 1'b0, 2'b00, 32'h0000_00FA, 32'h0000_00FA, 4'h0},  // R3
        '{1'b1, 1'b0, 2'b01, 32'hFFFF_85A5, 32'h0000_85A5, 4'h0},  // R3
        '{1'b1, 1'b1, 2'b10, 32'h8765_4321, 32'h8765_4321, 4'h0},  // R4
        '{1'b1, 1'b0, 2'b10, 32'hF000_000F, 32'hF000_000F, 4'h0},  // R4
        '{1'b0, 1'b1, 2'b10, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'hF},  // R4
        '{1'b0, 1'b1, 2'b00, 32'hFFFF_FF80, 32'h0000_0080, 4'h1},  // R5
        '{1'b0, 1'b0, 2'b00, 32'h1234_5678, 32'h0000_0078, 4'h1},  // R5
        '{1'b0, 1'b1, 2'b01, 32'h0000_7FFF, 32'h0000_7FFF, 4'h3},  // R5
        '{1'b0, 1'b0, 2'b01, 32'hCAFE_BABE, 32'h0000_BABE, 4'h3},  // R5
        '{1'b0, 1'b1, 2'b00, 32'h0000_0080, 32'h0000_0080, 4'h1}   // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one access on the falling edge.
    task automatic drive(input logic v, input logic ld, input logic sg, input logic [1:0] sz,
                         input logic [31:0] rw, input logic m, input logic c);
        @(negedge clk);
        acc_valid = v; acc_load = ld; acc_signed = sg; acc_size = sz;
        reg_wdata = rw; ovf_mask = m; ovf_clear = c;
    endtask

    // Return to an idle, non-overflowing input state.
    task automatic idle();
        drive(1'b0, 1'b1, 1'b0, 2'b10, 32'h0, 1'b1, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_load = 1'b1; acc_signed = 1'b0;
        acc_size = 2'b10; ovf_mask = 1'b1; ovf_clear = 1'b0;
        reg_wdata = '0; mem_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset sticky", {31'b0, ovf_sticky}, 32'h0);
        chk("R9 reset fault",  {31'b0, ovf_fault},  32'h0);
        rst_n = 1'b1;

        // Table walk over the combinational formatting (R1-R5 vectors tagged per line)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            acc_valid = 1'b0; acc_load = VEC[i].ld; acc_signed = VEC[i].sg; acc_size = VEC[i].sz;
            if (VEC[i].ld) mem_rdata = VEC[i].din; else reg_wdata = VEC[i].din;
            #1;
            if (VEC[i].ld) chk("R1/R2/R3/R4 load", ld_result, VEC[i].exp);
            else begin
                chk("R4/R5 store data", st_wdata, VEC[i].exp);
                chk("R4/R5 store be", {28'b0, st_be}, {28'b0, VEC[i].be});
            end
        end

        // R6 boundaries and R7: masked overflows set the sticky flag
        drive(1'b1, 1'b0, 1'b1, 2'b00, 32'h0000_007F, 1'b1, 1'b0);
        @(negedge clk); chk("R6 byte 127 fits", {31'b0, ovf_sticky}, 32'h0);
        drive(1'b1, 1'b0, 1'b1, 2'b00, 32'hFFFF_FF80, 1'b1, 1'b0);
        @(negedge clk); chk("R6 byte -128 fits", {31'b0, ovf_sticky}, 32'h0);
        drive(1'b1, 1'b0, 1'b0, 2'b00, 32'h1234_5678, 1'b1, 1'b0);
        @(negedge clk); chk("R6 unsigned never", {31'b0, ovf_sticky}, 32'h0);
        drive(1'b1, 1'b0, 1'b1, 2'b01, 32'hFFFF_8000, 1'b1, 1'b0);
        @(negedge clk); chk("R6 short -32768 fits", {31'b0, ovf_sticky}, 32'h0);
        drive(1'b1, 1'b0, 1'b1, 2'b10, 32'h8000_0000, 1'b1, 1'b0);
        @(negedge clk); chk("R4 word no ovf", {31'b0, ovf_sticky}, 32'h0);
        // R10: overflowing operand but invalid, then as a load
        drive(1'b0, 1'b0, 1'b1, 2'b00, 32'h0000_0080, 1'b1, 1'b0);
        @(negedge clk); chk("R10 invalid ignored", {31'b0, ovf_sticky}, 32'h0);
        drive(1'b1, 1'b1, 1'b1, 2'b00, 32'h0000_0080, 1'b0, 1'b0);
        @(negedge clk); chk("R10 load ignored", {31'b0, ovf_fault}, 32'h0);
        drive(1'b1, 1'b0, 1'b1, 2'b00, 32'h0000_0080, 1'b1, 1'b0);
        @(negedge clk);
        chk("R7 byte ovf sets sticky", {31'b0, ovf_sticky}, 32'h1);
        chk("R7 no fault when masked", {31'b0, ovf_fault}, 32'h0);
        idle();
        @(negedge clk); chk("R9 sticky holds", {31'b0, ovf_sticky}, 32'h1);
        // R9: clear wins over a simultaneous set
        drive(1'b1, 1'b0, 1'b1, 2'b01, 32'h0000_8000, 1'b1, 1'b1);
        @(negedge clk); chk("R9 clear wins", {31'b0, ovf_sticky}, 32'h0);
        // R6 short overflow just above range, masked
        drive(1'b1, 1'b0, 1'b1, 2'b01, 32'h0000_8000, 1'b1, 1'b0);
        @(negedge clk); chk("R6 short 32768 ovf", {31'b0, ovf_sticky}, 32'h1);
        drive(1'b0, 1'b1, 1'b0, 2'b10, 32'h0, 1'b1, 1'b1);
        idle();

        // R8: unmasked overflow gives a one-cycle fault, sticky unchanged
        drive(1'b1, 1'b0, 1'b1, 2'b00, 32'hFFFF_FF7F, 1'b0, 1'b0);
        idle();
        chk("R8 fault pulse", {31'b0, ovf_fault}, 32'h1);
        chk("R8 sticky untouched", {31'b0, ovf_sticky}, 32'h0);
        @(negedge clk); chk("R8 pulse ends", {31'b0, ovf_fault}, 32'h0);

        // Reset clears a set sticky flag
        drive(1'b1, 1'b0, 1'b1, 2'b00, 32'h0000_0100, 1'b1, 1'b0);
        idle();
        rst_n = 1'b0;
        @(negedge clk); chk("R9 reset clears", {31'b0, ovf_sticky}, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule